// File: doc/BRIEF.md
# Capacitive Touch Decision Filter

This block turns raw capacitance readings from a bank of touch channels into a filtered touch report. On every sample strobe it receives one 8-bit reading per channel. It compares each reading against a calibrated reference that it keeps for that channel. A reading that rises above the reference by more than the channel's touch margin is a hit. A reading that stays within the environmental margin above the reference is slow drift.

Hits are counted over an integration window of a programmable number of samples, which gives a strength per channel. At the end of each window the strengths are compared with per-channel thresholds. A selection mode then reduces the surviving channels to the touch byte: the strongest one, the strongest two, or all of them. References are refreshed automatically after all channels have stayed quiet for a while. While automatic tracking is held off, the host can refresh them on request instead. Every refresh gives a one-cycle end-of-calibration pulse.

Top module: `touch_filter`

## Requirements
- R1: A channel's sample is a hit when sample > reference + tvr for that channel (sample = reference + tvr is not a hit); hits feed that channel's strength.
- R2: A sample with sample <= reference + evr is quiet; any channel with sample > reference + evr breaks the quiet run, even when it is not a hit.
- R3: A window holds N valid samples (win_len, 0 treated as 1). At its last sample, strength becomes the number of hits in that window, so it never exceeds N. Strength and touch_byte change only at a window end.
- R4: A channel qualifies only when its strength is strictly greater than its own strength_thr.
- R5: sel_mode = 1 reports only the qualifying channel with the highest strength; on a tie the lower channel number wins.
- R6: sel_mode = 2 reports every qualifying channel (bit i of touch_byte is channel i).
- R7: sel_mode = 3 reports the two qualifying channels with the highest strengths, with lower channel numbers winning ties; sel_mode = 0 reports nothing.
- R8: With hold low, calibration runs on the wait_len-th consecutive all-quiet sample, then on every further cal_interval-th all-quiet sample (a limit of 0 means 1). Calibration copies each channel's current sample into its reference. A non-quiet sample or hold restarts the run from wait_len. Hold high stops automatic calibration.
- R9: req_uncond is latched only while hold is high. The next sample then calibrates unconditionally and clears uncond_pend. Dropping hold clears both pending flags.
- R10: req_cond is latched only while hold is high. It calibrates on the first sample with no hit on any channel and only then clears cond_pend.
- R11: eoc is high for the one cycle after every calibrating sample, automatic or host-driven. cal_ref shows the new references in that same cycle.
- R12: After reset, touch_byte, strength, cal_ref, eoc, uncond_pend and cond_pend are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-cycle strobe: samples holds a new reading for every channel |
| samples | input | NCH*DW | Channel readings, channel i in bits [i*DW +: DW] |
| tvr | input | NCH*TW | Per-channel touch margin |
| evr | input | TW | Environmental margin shared by all channels |
| strength_thr | input | NCH*SW | Per-channel strength threshold |
| win_len | input | SW | Integration window length in samples |
| sel_mode | input | 2 | 0 none, 1 strongest one, 2 all qualifying, 3 strongest two |
| hold | input | 1 | High stops automatic calibration and enables host requests |
| wait_len | input | QW | Quiet samples needed before the first automatic calibration |
| cal_interval | input | QW | Quiet samples between repeated automatic calibrations |
| req_uncond | input | 1 | Pulse: request an unconditional calibration |
| req_cond | input | 1 | Pulse: request a calibration that runs only with no hit |
| touch_byte | output | NCH | Filtered touch report |
| strength | output | NCH*SW | Strengths from the last completed window |
| cal_ref | output | NCH*DW | Current calibrated references |
| eoc | output | 1 | End-of-calibration pulse |
| uncond_pend | output | 1 | Unconditional request waiting |
| cond_pend | output | 1 | Conditional request waiting |

## Verification
The hardest state to reach is a long all-quiet run that spans the first wait and then several repeat intervals. Broken runs must also start the count again from the wait length, and all of this has to line up with window ends and host requests. Any hit, or any drift above the environmental margin on a single channel, breaks the run. Random stimulus therefore draws each reading as a small offset from the reference the bench itself tracks. It biases those offsets toward the margins and uses short wait and interval limits. Directed sequences pin the exact margin boundaries, strength ties between channels, and a conditional request blocked by a hit.

// File: rtl/touch_pkg.sv
package touch_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TOP1 = 2'd1,
    SEL_ALL  = 2'd2,
    SEL_TOP2 = 2'd3
  } sel_mode_e;
endpackage

// File: rtl/tf_compare.sv
module tf_compare #(
  parameter int DW = 8,
  parameter int TW = 7
) (
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] ref_val,
  input  logic [TW-1:0] tvr,
  input  logic [TW-1:0] evr,
  output logic          hit,
  output logic          quiet
);
  logic [DW:0] s_ext, hit_lim, quiet_lim;

  assign s_ext     = {1'b0, sample};
  assign hit_lim   = {1'b0, ref_val} + (DW+1)'(tvr);
  assign quiet_lim = {1'b0, ref_val} + (DW+1)'(evr);
  assign hit       = s_ext > hit_lim;
  assign quiet     = s_ext <= quiet_lim;
endmodule

// File: rtl/tf_strength.sv
module tf_strength #(
  parameter int NCH = 8,
  parameter int SW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [NCH-1:0]    hit,
  input  logic [SW-1:0]     win_len,
  output logic [NCH*SW-1:0] strength_nxt,
  output logic              win_end,
  output logic [NCH*SW-1:0] strength
);
  logic [SW-1:0] acc [NCH];
  logic [SW-1:0] wcnt;
  logic [SW:0]   len_eff;

  assign len_eff = (win_len == '0) ? (SW+1)'(1) : {1'b0, win_len};
  assign win_end = valid && (({1'b0, wcnt} + (SW+1)'(1)) >= len_eff);

  for (genvar g = 0; g < NCH; g++) begin : g_acc
    assign strength_nxt[g*SW +: SW] = acc[g] + SW'(hit[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt     <= '0;
      strength <= '0;
      for (int i = 0; i < NCH; i++) acc[i] <= '0;
    end else if (valid) begin
      if (win_end) begin
        wcnt     <= '0;
        strength <= strength_nxt;
        for (int i = 0; i < NCH; i++) acc[i] <= '0;
      end else begin
        wcnt <= wcnt + SW'(1);
        for (int i = 0; i < NCH; i++) acc[i] <= strength_nxt[i*SW +: SW];
      end
    end
  end
endmodule

// File: rtl/tf_select.sv
module tf_select
  import touch_pkg::*;
#(
  parameter int NCH = 8,
  parameter int SW  = 8
) (
  input  logic [NCH*SW-1:0] strength,
  input  logic [NCH*SW-1:0] thr,
  input  logic [1:0]        mode,
  output logic [NCH-1:0]    sel
);
  logic [NCH-1:0] ok, m1, m2;
  logic [SW-1:0]  bs1, bs2;
  logic           f1, f2;
  sel_mode_e      md;

  assign md = sel_mode_e'(mode);

  always_comb begin
    ok  = '0;
    m1  = '0;
    m2  = '0;
    bs1 = '0;
    bs2 = '0;
    f1  = 1'b0;
    f2  = 1'b0;
    for (int i = 0; i < NCH; i++)
      ok[i] = strength[i*SW +: SW] > thr[i*SW +: SW];
    for (int i = 0; i < NCH; i++) begin
      if (ok[i] && (!f1 || strength[i*SW +: SW] > bs1)) begin
        f1    = 1'b1;
        bs1   = strength[i*SW +: SW];
        m1    = '0;
        m1[i] = 1'b1;
      end
    end
    for (int i = 0; i < NCH; i++) begin
      if (ok[i] && !m1[i] && (!f2 || strength[i*SW +: SW] > bs2)) begin
        f2    = 1'b1;
        bs2   = strength[i*SW +: SW];
        m2    = '0;
        m2[i] = 1'b1;
      end
    end
    case (md)
      SEL_TOP1: sel = m1;
      SEL_ALL:  sel = ok;
      SEL_TOP2: sel = m1 | m2;
      default:  sel = '0;
    endcase
  end
endmodule

// File: rtl/tf_calib.sv
module tf_calib #(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          all_quiet,
  input  logic          any_hit,
  input  logic          hold,
  input  logic [QW-1:0] wait_len,
  input  logic [QW-1:0] interval,
  input  logic          req_u_set,
  input  logic          req_c_set,
  output logic          cal,
  output logic          u_pend,
  output logic          c_pend
);
  logic [QW-1:0] qcnt;
  logic          first;
  logic [QW:0]   lim_raw, lim;
  logic          auto_cal, host_cal;

  assign lim_raw  = first ? {1'b0, wait_len} : {1'b0, interval};
  assign lim      = (lim_raw == '0) ? (QW+1)'(1) : lim_raw;
  assign auto_cal = valid && !hold && all_quiet &&
                    (({1'b0, qcnt} + (QW+1)'(1)) >= lim);
  assign host_cal = valid && hold && (u_pend || (c_pend && !any_hit));
  assign cal      = auto_cal || host_cal;

  always_ff @(posedge clk) begin
    if (rst) begin
      qcnt   <= '0;
      first  <= 1'b1;
      u_pend <= 1'b0;
      c_pend <= 1'b0;
    end else begin
      if (valid) begin
        if (hold || !all_quiet) begin
          qcnt  <= '0;
          first <= 1'b1;
        end else if (auto_cal) begin
          qcnt  <= '0;
          first <= 1'b0;
        end else begin
          qcnt <= qcnt + QW'(1);
        end
      end
      u_pend <= hold && (req_u_set || (u_pend && !host_cal));
      c_pend <= hold && (req_c_set || (c_pend && !host_cal));
    end
  end
endmodule

// File: rtl/touch_filter.sv
module touch_filter #(
  parameter int NCH = 8,
  parameter int DW  = 8,
  parameter int TW  = 7,
  parameter int SW  = 8,
  parameter int QW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  input  logic [NCH*DW-1:0] samples,
  input  logic [NCH*TW-1:0] tvr,
  input  logic [TW-1:0]     evr,
  input  logic [NCH*SW-1:0] strength_thr,
  input  logic [SW-1:0]     win_len,
  input  logic [1:0]        sel_mode,
  input  logic              hold,
  input  logic [QW-1:0]     wait_len,
  input  logic [QW-1:0]     cal_interval,
  input  logic              req_uncond,
  input  logic              req_cond,
  output logic [NCH-1:0]    touch_byte,
  output logic [NCH*SW-1:0] strength,
  output logic [NCH*DW-1:0] cal_ref,
  output logic              eoc,
  output logic              uncond_pend,
  output logic              cond_pend
);
  logic [DW-1:0]     ref_q [NCH];
  logic [NCH-1:0]    hit, quiet, sel;
  logic [NCH*SW-1:0] strength_nxt;
  logic              win_end, cal;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tf_compare #(.DW(DW), .TW(TW)) u_cmp (
      .sample  (samples[g*DW +: DW]),
      .ref_val (ref_q[g]),
      .tvr     (tvr[g*TW +: TW]),
      .evr     (evr),
      .hit     (hit[g]),
      .quiet   (quiet[g])
    );
    assign cal_ref[g*DW +: DW] = ref_q[g];
  end

  tf_strength #(.NCH(NCH), .SW(SW)) u_str (
    .clk          (clk),
    .rst          (rst),
    .valid        (sample_valid),
    .hit          (hit),
    .win_len      (win_len),
    .strength_nxt (strength_nxt),
    .win_end      (win_end),
    .strength     (strength)
  );

  tf_select #(.NCH(NCH), .SW(SW)) u_sel (
    .strength (strength_nxt),
    .thr      (strength_thr),
    .mode     (sel_mode),
    .sel      (sel)
  );

  tf_calib #(.QW(QW)) u_cal (
    .clk       (clk),
    .rst       (rst),
    .valid     (sample_valid),
    .all_quiet (&quiet),
    .any_hit   (|hit),
    .hold      (hold),
    .wait_len  (wait_len),
    .interval  (cal_interval),
    .req_u_set (req_uncond),
    .req_c_set (req_cond),
    .cal       (cal),
    .u_pend    (uncond_pend),
    .c_pend    (cond_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc        <= 1'b0;
      touch_byte <= '0;
      for (int i = 0; i < NCH; i++) ref_q[i] <= '0;
    end else begin
      eoc <= cal;
      if (cal)
        for (int i = 0; i < NCH; i++) ref_q[i] <= samples[i*DW +: DW];
      if (win_end) touch_byte <= sel;
    end
  end
endmodule

// File: rtl/touch_filter_chk.sv
module touch_filter_chk #(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sample_valid,
  input logic              win_end,
  input logic [1:0]        sel_mode,
  input logic              hold,
  input logic [NCH-1:0]    touch_byte,
  input logic              eoc,
  input logic              uncond_pend,
  input logic              cond_pend,
  input logic [NCH*DW-1:0] cal_ref
);
  AST_EOC_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    eoc |-> $past(sample_valid)); // R11
  AST_REF_STABLE: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> $stable(cal_ref)); // R8
  AST_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (!uncond_pend && !cond_pend)); // R9
  AST_TOP1_ONE: assert property (@(posedge clk) disable iff (rst)
    (win_end && sel_mode == 2'd1) |=> ($countones(touch_byte) <= 1)); // R5
  AST_TOP2_TWO: assert property (@(posedge clk) disable iff (rst)
    (win_end && sel_mode == 2'd3) |=> ($countones(touch_byte) <= 2)); // R7
  AST_TOUCH_HELD: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(touch_byte)); // R3
endmodule

bind touch_filter touch_filter_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_valid (sample_valid),
  .win_end      (win_end),
  .sel_mode     (sel_mode),
  .hold         (hold),
  .touch_byte   (touch_byte),
  .eoc          (eoc),
  .uncond_pend  (uncond_pend),
  .cond_pend    (cond_pend),
  .cal_ref      (cal_ref)
);

// File: tb/tb_touch_filter.sv
`timescale 1ns/1ps
module tb_touch_filter;
  localparam int NCH = 8;
  localparam int DW  = 8;
  localparam int TW  = 7;
  localparam int SW  = 8;
  localparam int QW  = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, c_valid, c_hold, c_ru, c_rc;
  logic [DW-1:0] c_smp [NCH];
  logic [TW-1:0] c_tvr [NCH];
  logic [TW-1:0] c_evr;
  logic [SW-1:0] c_thr [NCH];
  logic [SW-1:0] c_win;
  logic [QW-1:0] c_wait, c_int;
  logic [1:0]    c_mode;

  logic [NCH*DW-1:0] samples;
  logic [NCH*TW-1:0] tvr;
  logic [NCH*SW-1:0] thr;
  logic [NCH-1:0]    touch_byte;
  logic [NCH*SW-1:0] strength;
  logic [NCH*DW-1:0] cal_ref;
  logic              eoc, uncond_pend, cond_pend;

  for (genvar g = 0; g < NCH; g++) begin : g_pack
    assign samples[g*DW +: DW] = c_smp[g];
    assign tvr[g*TW +: TW]     = c_tvr[g];
    assign thr[g*SW +: SW]     = c_thr[g];
  end

  touch_filter #(.NCH(NCH), .DW(DW), .TW(TW), .SW(SW), .QW(QW)) dut (
    .clk(clk), .rst(rst), .sample_valid(c_valid), .samples(samples),
    .tvr(tvr), .evr(c_evr), .strength_thr(thr), .win_len(c_win),
    .sel_mode(c_mode), .hold(c_hold), .wait_len(c_wait),
    .cal_interval(c_int), .req_uncond(c_ru), .req_cond(c_rc),
    .touch_byte(touch_byte), .strength(strength), .cal_ref(cal_ref),
    .eoc(eoc), .uncond_pend(uncond_pend), .cond_pend(cond_pend)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model state
  logic [7:0] m_ref [NCH];
  logic [7:0] m_acc [NCH];
  logic [7:0] m_str [NCH];
  logic [7:0] m_touch;
  int         m_wcnt, m_qcnt;
  bit         m_first, m_eoc, m_up, m_cp;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pick(input logic [7:0] st [NCH], input logic [1:0] mode);
    logic [7:0] ok, a, b;
    int best, second;
    ok = '0; a = '0; b = '0; best = -1; second = -1;
    for (int i = 0; i < NCH; i++) ok[i] = st[i] > c_thr[i];
    for (int i = 0; i < NCH; i++)
      if (ok[i] && (best < 0 || st[i] > st[best])) best = i;
    for (int i = 0; i < NCH; i++)
      if (ok[i] && i != best && (second < 0 || st[i] > st[second])) second = i;
    if (best >= 0) a[best] = 1'b1;
    if (second >= 0) b[second] = 1'b1;
    case (mode)
      2'd1: return a;
      2'd2: return ok;
      2'd3: return a | b;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [63:0] pack8(input logic [7:0] v [NCH]);
    logic [63:0] r;
    for (int i = 0; i < NCH; i++) r[i*8 +: 8] = v[i];
    return r;
  endfunction

  task automatic model_sample(input logic [7:0] s [NCH]);
    bit anyh, allq, autoc, hostc;
    logic [7:0] nxt [NCH];
    int len, lim;
    anyh = 1'b0; allq = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      bit h;
      h = int'(s[i]) > int'(m_ref[i]) + int'(c_tvr[i]);
      anyh |= h;
      allq &= (int'(s[i]) <= int'(m_ref[i]) + int'(c_evr));
      nxt[i] = m_acc[i] + 8'(h);
    end
    len = (c_win == 0) ? 1 : int'(c_win);
    if (m_wcnt + 1 >= len) begin
      for (int i = 0; i < NCH; i++) begin m_str[i] = nxt[i]; m_acc[i] = 8'h00; end
      m_touch = pick(nxt, c_mode);
      m_wcnt  = 0;
    end else begin
      for (int i = 0; i < NCH; i++) m_acc[i] = nxt[i];
      m_wcnt++;
    end
    lim = m_first ? int'(c_wait) : int'(c_int);
    if (lim == 0) lim = 1;
    autoc = !c_hold && allq && (m_qcnt + 1 >= lim);
    hostc = c_hold && (m_up || (m_cp && !anyh));
    if (c_hold || !allq) begin m_qcnt = 0; m_first = 1'b1; end
    else if (autoc) begin m_qcnt = 0; m_first = 1'b0; end
    else m_qcnt++;
    m_up  = c_hold && m_up && !hostc;
    m_cp  = c_hold && m_cp && !hostc;
    m_eoc = autoc || hostc;
    if (m_eoc) for (int i = 0; i < NCH; i++) m_ref[i] = s[i];
  endtask

  task automatic step(input logic [7:0] s [NCH]);
    string tt;
    @(negedge clk);
    for (int i = 0; i < NCH; i++) c_smp[i] = s[i];
    c_valid = 1'b1;
    model_sample(s);
    @(negedge clk);
    c_valid = 1'b0;
    tt = (c_mode == 2'd1) ? "R5" : (c_mode == 2'd2) ? "R6" : "R7";
    chk(tt, 64'(touch_byte), 64'(m_touch));
    chk("R3", strength, pack8(m_str));
    chk("R8", cal_ref, pack8(m_ref));
    chk("R11", 64'(eoc), 64'(m_eoc));
    chk("R9/R10", {62'd0, uncond_pend, cond_pend}, {62'd0, m_up, m_cp});
  endtask

  task automatic fill(input logic [7:0] v, output logic [7:0] s [NCH]);
    for (int i = 0; i < NCH; i++) s[i] = v;
  endtask

  task automatic set_hold(input bit v);
    @(negedge clk);
    c_hold = v;
    if (!v) begin m_up = 1'b0; m_cp = 1'b0; end
  endtask

  task automatic request(input bit u, input bit c);
    @(negedge clk);
    c_ru = u; c_rc = c;
    m_up = c_hold && (u || m_up);
    m_cp = c_hold && (c || m_cp);
    @(negedge clk);
    c_ru = 1'b0; c_rc = 1'b0;
    chk("R9/R10", {62'd0, uncond_pend, cond_pend}, {62'd0, m_up, m_cp});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s [NCH];
    void'($urandom(32'd20240611));
    rst = 1'b1; c_valid = 1'b0; c_hold = 1'b1; c_ru = 1'b0; c_rc = 1'b0;
    c_evr = 7'd4; c_win = 8'd15; c_mode = 2'd2; c_wait = 8'd3; c_int = 8'd3;
    for (int i = 0; i < NCH; i++) begin
      c_smp[i] = 8'h00; c_tvr[i] = 7'd8; c_thr[i] = 8'd1;
      m_ref[i] = 8'h00; m_acc[i] = 8'h00; m_str[i] = 8'h00;
    end
    m_touch = 8'h00; m_wcnt = 0; m_qcnt = 0; m_first = 1'b1;
    m_eoc = 1'b0; m_up = 1'b0; m_cp = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12", 64'(touch_byte), 64'h0);
    chk("R12", strength, 64'h0);
    chk("R12", cal_ref, 64'h0);
    chk("R12", {61'd0, eoc, uncond_pend, cond_pend}, 64'h0);

    // R1 margin boundary
    c_win = 8'd1;
    for (int i = 0; i < NCH; i++) begin c_thr[i] = 8'd0; c_tvr[i] = 7'd10; end
    fill(8'd0, s); s[0] = 8'd10; s[1] = 8'd11;
    step(s);
    chk("R1", 64'(touch_byte), 64'h02);

    // R4 threshold is strict
    c_win = 8'd3;
    for (int i = 0; i < NCH; i++) c_thr[i] = 8'd1;
    fill(8'd0, s); s[0] = 8'd20; s[1] = 8'd20; step(s);
    fill(8'd0, s); s[0] = 8'd20; step(s);
    fill(8'd0, s); step(s);
    chk("R4", 64'(touch_byte), 64'h01);
    chk("R3", 64'(strength[15:8]), 64'd1);

    // ties and modes
    c_win = 8'd1;
    for (int i = 0; i < NCH; i++) c_thr[i] = 8'd0;
    fill(8'd0, s); s[2] = 8'd50; s[5] = 8'd50; s[6] = 8'd50;
    c_mode = 2'd1; step(s); chk("R5", 64'(touch_byte), 64'h04);
    c_mode = 2'd3; step(s); chk("R7", 64'(touch_byte), 64'h24);
    c_mode = 2'd2; step(s); chk("R6", 64'(touch_byte), 64'h64);
    c_mode = 2'd0; step(s); chk("R7", 64'(touch_byte), 64'h00);
    c_win = 8'd2; c_mode = 2'd3;
    step(s);
    fill(8'd0, s); s[5] = 8'd50; s[6] = 8'd50; step(s);
    chk("R7", 64'(touch_byte), 64'h60);
    c_mode = 2'd1;
    fill(8'd0, s); s[2] = 8'd50; s[5] = 8'd50; s[6] = 8'd50; step(s);
    fill(8'd0, s); s[5] = 8'd50; s[6] = 8'd50; step(s);
    chk("R5", 64'(touch_byte), 64'h20);

    // host requests under hold
    request(1'b0, 1'b1);
    chk("R10", 64'(cond_pend), 64'd1);
    fill(8'd0, s); s[0] = 8'd50; step(s);
    chk("R10", 64'(cond_pend), 64'd1);
    chk("R10", cal_ref, 64'h0);
    fill(8'd3, s); step(s);
    chk("R10", cal_ref, {8{8'h03}});
    chk("R11", 64'(eoc), 64'd1);
    request(1'b1, 1'b0);
    fill(8'd0, s); s[0] = 8'd100; step(s);
    chk("R9", 64'(cal_ref[7:0]), 64'd100);
    chk("R9", 64'(uncond_pend), 64'd0);
    request(1'b1, 1'b0);
    fill(8'd0, s); step(s);
    chk("R9", cal_ref, 64'h0);
    set_hold(1'b0);
    request(1'b1, 1'b0);
    chk("R9", 64'(uncond_pend), 64'd0);

    // R2 / R8 quiet run and drift tracking
    c_wait = 8'd2; c_int = 8'd3; c_evr = 7'd4;
    for (int i = 0; i < NCH; i++) c_tvr[i] = 7'd20;
    fill(8'd4, s); step(s);
    chk("R8", 64'(eoc), 64'd0);
    step(s);
    chk("R8", 64'(eoc), 64'd1);
    chk("R8", cal_ref, {8{8'h04}});
    fill(8'd9, s); step(s);
    chk("R2", cal_ref, {8{8'h04}});
    fill(8'd8, s); step(s);
    chk("R2", 64'(eoc), 64'd0);
    step(s);
    chk("R2", cal_ref, {8{8'h08}});
    step(s); step(s);
    chk("R8", 64'(eoc), 64'd0);
    step(s);
    chk("R8", 64'(eoc), 64'd1);
    set_hold(1'b1);
    for (int k = 0; k < 4; k++) begin
      step(s);
      chk("R8", 64'(eoc), 64'd0);
    end

    // random phases
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < NCH; i++) begin
        c_tvr[i] = 7'($urandom_range(2, 20));
        c_thr[i] = 8'($urandom_range(0, 4));
      end
      c_evr  = 7'($urandom_range(0, 6));
      c_win  = 8'($urandom_range(0, 8));
      c_mode = 2'($urandom_range(0, 3));
      c_wait = 8'($urandom_range(0, 6));
      c_int  = 8'($urandom_range(0, 5));
      set_hold(bit'($urandom_range(0, 1)));
      for (int k = 0; k < 150; k++) begin
        for (int i = 0; i < NCH; i++) begin
          int v;
          if ($urandom_range(0, 3) == 0) v = int'(m_ref[i]) + $urandom_range(0, 30);
          else v = int'(m_ref[i]) + $urandom_range(0, 8) - 2;
          if (v < 0) v = 0;
          if (v > 255) v = 255;
          s[i] = 8'(v);
        end
        step(s);
        if ($urandom_range(0, 19) == 0) set_hold(~c_hold);
        if (c_hold && $urandom_range(0, 9) == 0)
          request(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
        if ($urandom_range(0, 29) == 0) c_mode = 2'($urandom_range(0, 3));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule